// File: doc/BRIEF.md
# Barrel Shift and Rotate Unit

This combinational unit computes the result of the integer shift and rotate instructions of a 32-bit load/store datapath. From the function code, the register-index fields and the 5-bit shift-amount field, it works out which operation is meant. The operations are logical left, logical right, arithmetic right and rotate right. Each comes in two forms: one takes its count from the instruction, the other takes it from a register value. The unit then applies that operation to the source word in a single pass through a logarithmic shifter.

Logical right and rotate right share their function codes. The two are told apart by one field bit. In the fixed-count forms this is the low bit of the rs field. In the register-count forms it is the low bit of the shift-amount field. A left shift whose register fields are all zero, with a shift amount of 0, 1 or 3, is not a shift. These encodings are the no-op and hint forms, and the unit raises a flag for them instead of producing a shifted word.

The unit holds no state: there are no states and no transitions, and both outputs follow the inputs in the same cycle.

Top module: `shf_unit`

## Requirements
- R1: Function code 0 shifts `src_val` left by `sa_fld`, and function code 4 shifts it left by `amt_val[4:0]`. Both fill the vacated low bits with zeros.
- R2: Function code 2 with `rs_idx[0]`=0 is a logical right shift by `sa_fld`. Function code 6 with `sa_fld[0]`=0 is a logical right shift by `amt_val[4:0]`. Both fill the vacated high bits with zeros.
- R3: Function codes 3 (count from `sa_fld`) and 7 (count from `amt_val[4:0]`) shift right and fill the vacated high bits with copies of `src_val[31]`.
- R4: Function code 2 with `rs_idx[0]`=1, and function code 6 with `sa_fld[0]`=1, rotate right. The result equals (x << (32-n)) | (x >> n).
- R5: A rotate right by a count of 0 returns `src_val` unchanged.
- R6: The register-count forms (codes 4, 6, 7) use only bits 4:0 of `amt_val`. Setting any higher bit of `amt_val` leaves `shift_res` unchanged.
- R7: In the fixed-count forms (codes 0, 2, 3), `amt_val` has no effect. In code 2, `rs_idx` bits other than bit 0 have no effect.
- R8: Code 0 with `rs_idx`, `rt_idx` and `rd_idx` all zero and `sa_fld` equal to 0, 1 or 3 sets `is_hint`=1 and `shift_res`=0. Any other code-0 encoding gives `is_hint`=0 and an ordinary left shift.
- R9: Any function code other than 0, 2, 3, 4, 6 and 7 gives `shift_res`=0 and `is_hint`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fn_code | input | 6 | Function code of the instruction |
| rs_idx | input | 5 | rs register-index field; bit 0 picks rotate in code 2 |
| rt_idx | input | 5 | rt register-index field; used only for hint detection |
| rd_idx | input | 5 | rd register-index field; used only for hint detection |
| sa_fld | input | 5 | Shift-amount field; bit 0 picks rotate in code 6 |
| src_val | input | 32 | Word to be shifted or rotated |
| amt_val | input | 32 | Register value supplying the count for the register-count forms |
| shift_res | output | 32 | Shifted or rotated word |
| is_hint | output | 1 | High when the encoding is a no-op or hint form |

## Verification
Every implemented function code is swept over all 32 counts with random source words. Both settings of the select bit are used, which separates rotation from zero fill and sign fill from zero fill. Sign-heavy words such as 0x80000000 expose errors in the fill. Register counts with high bits set show whether the count is truncated to 5 bits. Code-0 encodings are tried with each hint amount, with a non-hint amount and with one non-zero register field, so that the hint boundary is checked from both sides. Unused function codes are checked for a zero result.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SK_LEFT  = 2'd0,
        SK_LOGR  = 2'd1,
        SK_ARITH = 2'd2,
        SK_ROTR  = 2'd3
    } shf_kind_e;

    localparam logic [5:0] FN_SLL_IMM  = 6'd0;
    localparam logic [5:0] FN_SRL_IMM  = 6'd2;
    localparam logic [5:0] FN_SRA_IMM  = 6'd3;
    localparam logic [5:0] FN_SLL_VAR  = 6'd4;
    localparam logic [5:0] FN_SRL_VAR  = 6'd6;
    localparam logic [5:0] FN_SRA_VAR  = 6'd7;

    localparam logic [4:0] HINT_PLAIN  = 5'd0;
    localparam logic [4:0] HINT_SUPER  = 5'd1;
    localparam logic [4:0] HINT_BARR   = 5'd3;

endpackage

// File: rtl/shf_decode.sv
module shf_decode
    import shf_pkg::*;
#(
    parameter int IW = 5,
    parameter int AW = 5
) (
    input  logic [5:0]    fn_code,
    input  logic [IW-1:0] rs_idx,
    input  logic [IW-1:0] rt_idx,
    input  logic [IW-1:0] rd_idx,
    input  logic [AW-1:0] sa_fld,
    output shf_kind_e     kind,
    output logic          use_var,
    output logic          legal,
    output logic          hint
);

    logic regs_zero;

    always_comb begin
        regs_zero = (rs_idx == '0) && (rt_idx == '0) && (rd_idx == '0);
    end

    always_comb begin
        kind    = SK_LEFT;
        use_var = 1'b0;
        legal   = 1'b1;
        hint    = 1'b0;
        case (fn_code)
            FN_SLL_IMM: begin
                kind = SK_LEFT;
                hint = regs_zero && ((sa_fld == HINT_PLAIN) ||
                                     (sa_fld == HINT_SUPER) ||
                                     (sa_fld == HINT_BARR));
            end
            FN_SRL_IMM: kind = rs_idx[0] ? SK_ROTR : SK_LOGR;
            FN_SRA_IMM: kind = SK_ARITH;
            FN_SLL_VAR: begin
                kind    = SK_LEFT;
                use_var = 1'b1;
            end
            FN_SRL_VAR: begin
                kind    = sa_fld[0] ? SK_ROTR : SK_LOGR;
                use_var = 1'b1;
            end
            FN_SRA_VAR: begin
                kind    = SK_ARITH;
                use_var = 1'b1;
            end
            default: legal = 1'b0;
        endcase
    end

    always_comb begin
        if (hint) begin
            AST_HINT_ONLY_LEFT: assert (fn_code == FN_SLL_IMM && !use_var); // R8
        end
    end

endmodule

// File: rtl/shf_stage_net.sv
module shf_stage_net #(
    parameter int DW = 32,
    parameter int AW = $clog2(DW)
) (
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] amt,
    input  logic          rot,
    input  logic          fill,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] stg [AW+1];

    assign stg[0] = din;

    for (genvar k = 0; k < AW; k++) begin : g_stg
        localparam int STEP = 1 << k;
        logic [STEP-1:0] ins;
        always_comb begin
            ins = rot ? stg[k][STEP-1:0] : {STEP{fill}};
        end
        assign stg[k+1] = amt[k] ? {ins, stg[k][DW-1:STEP]} : stg[k];
    end

    assign dout = stg[AW];

endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int DW = 32,
    parameter int IW = 5
) (
    input  logic [5:0]    fn_code,
    input  logic [IW-1:0] rs_idx,
    input  logic [IW-1:0] rt_idx,
    input  logic [IW-1:0] rd_idx,
    input  logic [4:0]    sa_fld,
    input  logic [DW-1:0] src_val,
    input  logic [DW-1:0] amt_val,
    output logic [DW-1:0] shift_res,
    output logic          is_hint
);

    localparam int AW = $clog2(DW);

    shf_kind_e     kind_w;
    logic          var_w;
    logic          legal_w;
    logic          hint_w;
    logic [AW-1:0] amt_sel;
    logic          left_w;
    logic [DW-1:0] net_in;
    logic [DW-1:0] net_out;
    logic [DW-1:0] res_w;

    shf_decode #(.IW(IW), .AW(AW)) u_dec (
        .fn_code (fn_code),
        .rs_idx  (rs_idx),
        .rt_idx  (rt_idx),
        .rd_idx  (rd_idx),
        .sa_fld  (sa_fld),
        .kind    (kind_w),
        .use_var (var_w),
        .legal   (legal_w),
        .hint    (hint_w)
    );

    assign amt_sel = var_w ? amt_val[AW-1:0] : sa_fld;
    assign left_w  = (kind_w == SK_LEFT);

    for (genvar i = 0; i < DW; i++) begin : g_rev
        assign net_in[i] = left_w ? src_val[DW-1-i] : src_val[i];
        assign res_w[i]  = left_w ? net_out[DW-1-i] : net_out[i];
    end

    shf_stage_net #(.DW(DW), .AW(AW)) u_net (
        .din  (net_in),
        .amt  (amt_sel),
        .rot  (kind_w == SK_ROTR),
        .fill ((kind_w == SK_ARITH) && src_val[DW-1]),
        .dout (net_out)
    );

    assign shift_res = (legal_w && !hint_w) ? res_w : '0;
    assign is_hint   = hint_w;

    always_comb begin
        if (hint_w) begin
            AST_HINT_FIELDS: assert (rs_idx == '0 && rt_idx == '0 && rd_idx == '0); // R8
        end
        if (legal_w && kind_w == SK_ROTR && amt_sel == '0) begin
            AST_ROT_IDENT: assert (net_out == src_val); // R5
        end
        if (legal_w && !hint_w && kind_w == SK_LEFT) begin
            AST_LEFT_ZFILL: assert ((shift_res & ((DW'(1) << amt_sel) - DW'(1))) == '0); // R1
        end
        if (legal_w && kind_w == SK_ARITH && src_val[DW-1]) begin
            AST_ARITH_SIGN: assert (shift_res[DW-1]); // R3
        end
        if (var_w) begin
            AST_VAR_WRAP: assert (DW'(amt_sel) == (amt_val % DW)); // R6
        end
    end

endmodule

// File: tb/shf_unit_tb.sv
module shf_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [5:0]  fn_code = '0;
    logic [4:0]  rs_idx = '0, rt_idx = '0, rd_idx = '0, sa_fld = '0;
    logic [31:0] src_val = '0, amt_val = '0;
    logic [31:0] shift_res;
    logic        is_hint;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] q_res[$];
    logic        q_hint[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    shf_unit u_dut (
        .fn_code   (fn_code),
        .rs_idx    (rs_idx),
        .rt_idx    (rt_idx),
        .rd_idx    (rd_idx),
        .sa_fld    (sa_fld),
        .src_val   (src_val),
        .amt_val   (amt_val),
        .shift_res (shift_res),
        .is_hint   (is_hint)
    );

    function automatic logic [32:0] model(input logic [5:0] f, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [4:0] rd,
                                          input logic [4:0] sa, input logic [31:0] x,
                                          input logic [31:0] a);
        logic [4:0]  n;
        logic        rot;
        logic        h;
        logic [31:0] r;
        logic [63:0] dbl;
        n   = (f == 6'd4 || f == 6'd6 || f == 6'd7) ? a[4:0] : sa;
        rot = (f == 6'd2) ? rs[0] : (f == 6'd6) ? sa[0] : 1'b0;
        h   = (f == 6'd0) && rs == 0 && rt == 0 && rd == 0 && (sa == 0 || sa == 1 || sa == 3);
        dbl = {x, x} >> n;
        case (f)
            6'd0, 6'd4: r = x << n;
            6'd2, 6'd6: r = rot ? dbl[31:0] : (x >> n);
            6'd3, 6'd7: r = 32'($signed(x) >>> n);
            default:    r = 32'd0;
        endcase
        if (h) r = 32'd0;
        return {h, r};
    endfunction

    task automatic drive(input logic [5:0] f, input logic [4:0] rs, input logic [4:0] rt,
                         input logic [4:0] rd, input logic [4:0] sa, input logic [31:0] x,
                         input logic [31:0] a, input string tag);
        logic [32:0] e;
        @(posedge clk);
        #1;
        fn_code = f; rs_idx = rs; rt_idx = rt; rd_idx = rd; sa_fld = sa;
        src_val = x; amt_val = a;
        e = model(f, rs, rt, rd, sa, x, a);
        q_res.push_back(e[31:0]);
        q_hint.push_back(e[32]);
        q_tag.push_back(tag);
    endtask

    always @(negedge clk) begin
        if (q_res.size() > 0) begin
            logic [31:0] er;
            logic        eh;
            string       tg;
            er = q_res.pop_front();
            eh = q_hint.pop_front();
            tg = q_tag.pop_front();
            total++;
            if (shift_res !== er || is_hint !== eh) begin
                bad++;
                $display("FAIL %s fn=%0d sa=%0d: actual res=%h hint=%b expected res=%h hint=%b",
                         tg, fn_code, sa_fld, shift_res, is_hint, er, eh);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R8: idle all-zero encoding is the plain no-op
        drive(6'd0, 0, 0, 0, 0, 32'h0, 32'h0, "R8");
        drive(6'd0, 0, 0, 0, 1, 32'hDEAD_BEEF, 32'h0, "R8");
        drive(6'd0, 0, 0, 0, 3, 32'h1234_5678, 32'h0, "R8");
        drive(6'd0, 0, 0, 0, 2, 32'h0000_0001, 32'h0, "R8");
        drive(6'd0, 0, 0, 1, 0, 32'hCAFE_0001, 32'h0, "R8");
        drive(6'd0, 0, 1, 0, 3, 32'h0000_0011, 32'h0, "R8");
        // R9: unused function codes
        drive(6'd1, 3, 4, 5, 6, 32'hFFFF_FFFF, 32'h3, "R9");
        drive(6'd5, 3, 4, 5, 6, 32'hFFFF_FFFF, 32'h3, "R9");
        drive(6'd8, 0, 0, 0, 0, 32'hA5A5_A5A5, 32'h1, "R9");
        drive(6'h3F, 0, 0, 0, 0, 32'hA5A5_A5A5, 32'h1, "R9");
        // R5: rotate by zero
        drive(6'd2, 1, 2, 3, 0, 32'h8000_0001, 32'hFFFF_FFFF, "R5");
        drive(6'd6, 0, 2, 3, 1, 32'h8765_4321, 32'hFFFF_FFE0, "R5");
        // R3: sign fill boundaries
        drive(6'd3, 0, 2, 3, 31, 32'h8000_0000, 32'h0, "R3");
        drive(6'd7, 0, 2, 3, 0, 32'h8000_0000, 32'd31, "R3");
        // R6: high bits of the register count are ignored
        drive(6'd4, 0, 2, 3, 0, 32'h0000_00F1, 32'hFFFF_FFE4, "R6");
        drive(6'd6, 0, 2, 3, 0, 32'hF000_0000, 32'h8000_0008, "R6");
        drive(6'd7, 0, 2, 3, 0, 32'h8000_0000, 32'h7FFF_FFE1, "R6");
        // R7: fixed-count forms ignore amt_val and upper rs bits
        drive(6'd0, 5, 2, 3, 4, 32'h0000_000F, 32'hFFFF_FFFF, "R7");
        drive(6'd2, 30, 2, 3, 4, 32'hF000_0000, 32'h0000_0011, "R7");
        drive(6'd2, 31, 2, 3, 4, 32'h0000_000F, 32'h0000_0011, "R7");
        // R1 R2 R3 R4: sweep every code and count
        for (int f = 0; f < 8; f++) begin
            if (f == 0 || f == 2 || f == 3 || f == 4 || f == 6 || f == 7) begin
                for (int n = 0; n < 32; n++) begin
                    for (int s = 0; s < 2; s++) begin
                        logic [31:0] x;
                        logic [4:0]  rs;
                        logic [4:0]  sa;
                        logic [31:0] a;
                        string       tg;
                        x  = $urandom();
                        if (s == 1) x[31] = 1'b1;
                        a  = {$urandom() & 32'hFFFF_FFE0} | 32'(n);
                        rs = {4'd7, 1'(s)};
                        sa = (f == 4 || f == 6 || f == 7) ? {4'd5, 1'(s)} : 5'(n);
                        if (f == 0 || f == 4) tg = "R1";
                        else if (f == 3 || f == 7) tg = "R3";
                        else if (s == 1) tg = "R4";
                        else tg = "R2";
                        drive(6'(f), rs, 5'd9, 5'd10, sa, x, a, tg);
                    end
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule